// File: doc/BRIEF.md
# Programmable Interval Timer Channel

A single 16-bit down-counting timer channel with a byte-wide host port. Software selects a channel configuration with an 8-bit mode word, loads the reload value through one or two byte writes, and then lets the channel count on a slow reference tick that arrives as a one-cycle enable in the system clock domain. Two behaviours are built: a one-shot count that raises its output when the count runs out, and a square-wave generator whose period equals the loaded count in ticks.

A small control register next to the counter gates counting on or off, enables the speaker line, and shows the counter output as a status bit that software can poll to learn that a one-shot count has finished. A latch command freezes a copy of the running count so that it can be read out as two bytes while the live counter goes on.

The host port takes one access per cycle: `wr` or `rd` (never both) with `sel` choosing the target: 0 = count data, 1 = mode word, 2 = control register, 3 = unused.

Top module: `pit_chan`

## Requirements
- R1: After reset the speaker line is 0, a control read returns 0x00, and the channel is unarmed with one-shot operation and two-byte access selected.
- R2: Mode word fields: bits[7:6] channel, bits[5:4] access, bits[3:1] operation (3 = square wave, any other value = one-shot), bit0 format. A word whose channel is not the `CHAN` parameter (default 2) changes nothing; the format bit has no effect and counting is always binary.
- R3: With access 1 a single data write loads the count with that byte as low byte and 0 as high byte; with access 2 it loads that byte as high byte and 0 as low byte. Either write arms the counter.
- R4: With access 3 the first data write after a mode word holds the low byte and the second supplies the high byte; the counter is armed only by the second write.
- R5: While control bit0 (gate) is 0 the counter and output hold their values.
- R6: One-shot: the output goes to 0 on the mode word and on each load, goes to 1 on the tick that brings the count from 1 to 0 (N ticks after load, a count of 0 meaning 65536) and stays 1 until the next load or mode word.
- R7: Square wave: the output is 1 right after a load; it stays 1 for ceil(N/2) ticks and 0 for floor(N/2) ticks, repeating, where a count of 0 means 65536; a count of 1 keeps the output at 1.
- R8: A mode word with access 0 snapshots the current count; the next two data reads return its low then its high byte while the counter keeps running. A second snapshot command before both bytes are read is ignored.
- R9: Without a pending snapshot a data read returns the live count: low byte with access 1, high byte with access 2, alternately low then high with access 3 (restarting at low on each mode word).
- R10: Control writes set bit0 (gate) and bit1 (speaker enable); every other written bit is ignored. Control reads return gate in bit0, speaker enable in bit1, the counter output in bit5 and 0 elsewhere.
- R11: `spk_out` equals the counter output AND the speaker enable.
- R12: Read data appears on `rdata` one cycle after the read strobe and holds until the next read; reads with `sel` = 3 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Reference tick enable, one cycle per count step |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| sel | input | 2 | Target: 0 data, 1 mode word, 2 control |
| wdata | input | BYTE_W | Write data |
| rdata | output | BYTE_W | Registered read data |
| spk_out | output | 1 | Speaker line |

## Verification
The hardest state to reach from the ports is the longest one-shot count, a loaded value of 0 that must run for 65536 ticks before the output rises; the bench drives the tick every cycle for that case so it completes within the cycle budget. Snapshot reads interleaved with a running counter, a repeated snapshot command and a gate that drops in mid-count are produced by ordering host writes between ticks, and a cycle-by-cycle model compares the speaker line and every read byte.

// File: rtl/pit_pkg.sv
package pit_pkg;
  typedef enum logic [1:0] {
    ACC_SNAP = 2'd0,
    ACC_LO   = 2'd1,
    ACC_HI   = 2'd2,
    ACC_BOTH = 2'd3
  } acc_e;

  localparam logic [1:0] SEL_DATA = 2'd0;
  localparam logic [1:0] SEL_MODE = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;
  localparam logic [2:0] OP_SQUARE = 3'd3;
endpackage

// File: rtl/pit_host_port.sv
module pit_host_port
  import pit_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int CHAN   = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_i,
  input  logic                  rd_i,
  input  logic [1:0]            sel_i,
  input  logic [BYTE_W-1:0]     wdata_i,
  input  logic [2*BYTE_W-1:0]   cnt_i,
  input  logic                  out_i,
  output logic                  load_o,
  output logic [2*BYTE_W-1:0]   reload_o,
  output logic                  mode_set_o,
  output logic                  mode_sq_o,
  output logic                  sq_o,
  output logic                  gate_o,
  output logic                  spk_en_o,
  output logic [BYTE_W-1:0]     rdata_o
);
  localparam int CNT_W = 2 * BYTE_W;
  localparam logic [1:0] CHAN_ID = 2'(CHAN);

  acc_e              acc_q;
  logic              sq_q, wptr_q, rptr_q, snap_q, gate_q, spk_q;
  logic [BYTE_W-1:0] lo_q, rdata_q;
  logic [CNT_W-1:0]  snapv_q;

  logic wr_data, rd_data, mode_hit, snap_cmd;
  logic [BYTE_W-1:0] data_byte, ctrl_byte;

  assign wr_data    = wr_i && (sel_i == SEL_DATA);
  assign rd_data    = rd_i && !wr_i && (sel_i == SEL_DATA);
  assign mode_hit   = wr_i && (sel_i == SEL_MODE) && (wdata_i[7:6] == CHAN_ID);
  assign snap_cmd   = mode_hit && (wdata_i[5:4] == ACC_SNAP);
  assign mode_set_o = mode_hit && !snap_cmd;
  assign mode_sq_o  = (wdata_i[3:1] == OP_SQUARE);

  assign load_o = wr_data && ((acc_q == ACC_LO) || (acc_q == ACC_HI) ||
                              ((acc_q == ACC_BOTH) && wptr_q));

  always_comb begin
    case (acc_q)
      ACC_LO:  reload_o = {{BYTE_W{1'b0}}, wdata_i};
      ACC_HI:  reload_o = {wdata_i, {BYTE_W{1'b0}}};
      default: reload_o = {wdata_i, lo_q};
    endcase
  end

  always_comb begin
    if (snap_q)
      data_byte = rptr_q ? snapv_q[CNT_W-1:BYTE_W] : snapv_q[BYTE_W-1:0];
    else if (acc_q == ACC_HI)
      data_byte = cnt_i[CNT_W-1:BYTE_W];
    else if (acc_q == ACC_LO)
      data_byte = cnt_i[BYTE_W-1:0];
    else
      data_byte = rptr_q ? cnt_i[CNT_W-1:BYTE_W] : cnt_i[BYTE_W-1:0];
    ctrl_byte    = '0;
    ctrl_byte[0] = gate_q;
    ctrl_byte[1] = spk_q;
    ctrl_byte[5] = out_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= ACC_BOTH;
      sq_q    <= 1'b0;
      wptr_q  <= 1'b0;
      rptr_q  <= 1'b0;
      snap_q  <= 1'b0;
      snapv_q <= '0;
      lo_q    <= '0;
      gate_q  <= 1'b0;
      spk_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (wr_i && (sel_i == SEL_CTRL)) begin
        gate_q <= wdata_i[0];
        spk_q  <= wdata_i[1];
      end
      if (snap_cmd && !snap_q) begin
        snap_q  <= 1'b1;
        snapv_q <= cnt_i;
        rptr_q  <= 1'b0;
      end
      if (mode_set_o) begin
        acc_q  <= acc_e'(wdata_i[5:4]);
        sq_q   <= mode_sq_o;
        wptr_q <= 1'b0;
        rptr_q <= 1'b0;
        snap_q <= 1'b0;
      end
      if (wr_data && (acc_q == ACC_BOTH)) begin
        if (!wptr_q) lo_q <= wdata_i;
        wptr_q <= !wptr_q;
      end
      if (rd_i && !wr_i) begin
        case (sel_i)
          SEL_DATA: rdata_q <= data_byte;
          SEL_CTRL: rdata_q <= ctrl_byte;
          default:  rdata_q <= '0;
        endcase
      end
      if (rd_data && (snap_q || (acc_q == ACC_BOTH))) begin
        rptr_q <= !rptr_q;
        if (snap_q && rptr_q) snap_q <= 1'b0;
      end
    end
  end

  assign sq_o     = sq_q;
  assign gate_o   = gate_q;
  assign spk_en_o = spk_q;
  assign rdata_o  = rdata_q;

  // R8: a pending snapshot is never overwritten
  p_snap_hold_r8: assert property (@(posedge clk) disable iff (rst)
    snap_q |=> $stable(snapv_q));
  // R4: the low byte of a two-byte sequence never arms the counter
  p_split_load_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_data && (acc_q == ACC_BOTH) && !wptr_q) |=> !$past(load_o) && wptr_q);
endmodule

// File: rtl/pit_count_core.sv
module pit_count_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             gate_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             mode_set_i,
  input  logic             mode_sq_i,
  input  logic             sq_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             out_o
);
  logic [CNT_W-1:0] cnt_q, rel_q, hi_cur, lo_cur;
  logic             out_q, armed_q;

  // Half lengths of a square period; a zero count stands for 2**CNT_W.
  function automatic logic [CNT_W-1:0] half_len(input logic [CNT_W-1:0] r,
                                                input logic upper);
    logic [CNT_W-1:0] lo;
    lo = {(r == '0), r[CNT_W-1:1]};
    return upper ? (lo + {{(CNT_W-1){1'b0}}, r[0]}) : lo;
  endfunction

  assign hi_cur = half_len(rel_q, 1'b1);
  assign lo_cur = half_len(rel_q, 1'b0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      rel_q   <= '0;
      out_q   <= 1'b0;
      armed_q <= 1'b0;
    end else if (mode_set_i) begin
      armed_q <= 1'b0;
      out_q   <= mode_sq_i;
    end else if (load_i) begin
      armed_q <= 1'b1;
      rel_q   <= reload_i;
      if (sq_i) begin
        cnt_q <= half_len(reload_i, 1'b1);
        out_q <= 1'b1;
      end else begin
        cnt_q <= reload_i;
        out_q <= 1'b0;
      end
    end else if (tick_i && gate_i && armed_q) begin
      if (sq_i) begin
        if (cnt_q == CNT_W'(1)) begin
          if (out_q && (lo_cur != '0)) begin
            out_q <= 1'b0;
            cnt_q <= lo_cur;
          end else begin
            out_q <= 1'b1;
            cnt_q <= hi_cur;
          end
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end else begin
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) out_q <= 1'b1;
      end
    end
  end

  assign cnt_o = cnt_q;
  assign out_o = out_q;

  // R5: a closed gate freezes the count
  p_gate_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!gate_i && !load_i && !mode_set_i) |=> ($stable(cnt_q) && $stable(out_q)));
  // R6: a finished one-shot stays high until reloaded
  p_oneshot_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (!sq_i && out_q && !load_i && !mode_set_i) |=> out_q);
  // R7: an armed square wave never sits at a zero half count
  p_square_nonzero_r7: assert property (@(posedge clk) disable iff (rst)
    (armed_q && sq_i) |-> (cnt_q != '0));
endmodule

// File: rtl/pit_chan.sv
module pit_chan
  import pit_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int CHAN   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr,
  input  logic              rd,
  input  logic [1:0]        sel,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic              spk_out
);
  localparam int CNT_W = 2 * BYTE_W;

  logic             load, mode_set, mode_sq, sq, gate, spk_en, out;
  logic [CNT_W-1:0] reload, cnt;

  pit_host_port #(.BYTE_W(BYTE_W), .CHAN(CHAN)) host_i (
    .clk(clk), .rst(rst), .wr_i(wr), .rd_i(rd), .sel_i(sel), .wdata_i(wdata),
    .cnt_i(cnt), .out_i(out), .load_o(load), .reload_o(reload),
    .mode_set_o(mode_set), .mode_sq_o(mode_sq), .sq_o(sq), .gate_o(gate),
    .spk_en_o(spk_en), .rdata_o(rdata)
  );

  pit_count_core #(.CNT_W(CNT_W)) core_i (
    .clk(clk), .rst(rst), .tick_i(tick), .gate_i(gate), .load_i(load),
    .reload_i(reload), .mode_set_i(mode_set), .mode_sq_i(mode_sq), .sq_i(sq),
    .cnt_o(cnt), .out_o(out)
  );

  assign spk_out = out & spk_en;

  // R11: the speaker line is silent whenever its enable is off
  p_spk_gate_r11: assert property (@(posedge clk) disable iff (rst)
    !spk_en |-> !spk_out);
endmodule

// File: tb/pit_chan_tb_top.sv
module pit_chan_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [1:0] sel = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       spk_out;

  int compared = 0, mismatched = 0, cyc = 0, tick_div = 2;
  bit tick_on = 1'b0, done = 1'b0;
  string tag = "R1";

  // reference model state
  int m_acc, m_cnt, m_rel, m_lo, m_latv, m_rd_exp;
  bit m_sq, m_wptr, m_rptr, m_lat, m_gate, m_spk, m_out, m_armed, m_rd_valid;

  always #4 clk = ~clk;

  pit_chan dut_i (.clk(clk), .rst(rst), .tick(tick), .wr(wr), .rd(rd),
                  .sel(sel), .wdata(wdata), .rdata(rdata), .spk_out(spk_out));

  function automatic int halfn(int r, bit upper);
    int n = (r == 0) ? 65536 : r;
    return upper ? (n + 1) / 2 : n / 2;
  endfunction

  always @(posedge clk) begin
    int  c0, ld;
    bit  o0, ticking, mset;
    m_rd_valid = 1'b0;
    if (rst) begin
      m_acc = 3; m_cnt = 0; m_rel = 0; m_lo = 0; m_latv = 0; m_rd_exp = 0;
      m_sq = 0; m_wptr = 0; m_rptr = 0; m_lat = 0; m_gate = 0; m_spk = 0;
      m_out = 0; m_armed = 0;
    end else begin
      c0 = m_cnt; o0 = m_out; ld = 0;
      ticking = tick && m_gate && m_armed;
      mset = wr && sel == 2'd1 && wdata[7:6] == 2'd2 && wdata[5:4] != 2'd0;
      if (rd && !wr) begin
        m_rd_valid = 1'b1;
        if (sel == 2'd0) begin
          if (m_lat) begin
            m_rd_exp = m_rptr ? (m_latv >> 8) : (m_latv & 255);
            if (m_rptr) m_lat = 0;
            m_rptr = !m_rptr;
          end else if (m_acc == 1) m_rd_exp = c0 & 255;
          else if (m_acc == 2) m_rd_exp = c0 >> 8;
          else begin
            m_rd_exp = m_rptr ? (c0 >> 8) : (c0 & 255);
            m_rptr = !m_rptr;
          end
        end else if (sel == 2'd2) m_rd_exp = (int'(o0) << 5) | (int'(m_spk) << 1) | int'(m_gate);
        else m_rd_exp = 0;
      end
      if (wr && sel == 2'd2) begin m_gate = wdata[0]; m_spk = wdata[1]; end
      if (wr && sel == 2'd1 && wdata[7:6] == 2'd2 && wdata[5:4] == 2'd0 && !m_lat) begin
        m_lat = 1; m_latv = c0; m_rptr = 0;
      end
      if (mset) begin
        m_acc = wdata[5:4]; m_sq = (wdata[3:1] == 3'd3);
        m_wptr = 0; m_rptr = 0; m_lat = 0; m_armed = 0; m_out = m_sq;
      end else if (wr && sel == 2'd0) begin
        if (m_acc == 1) begin m_rel = wdata; ld = 1; end
        else if (m_acc == 2) begin m_rel = int'(wdata) << 8; ld = 1; end
        else if (!m_wptr) begin m_lo = wdata; m_wptr = 1; end
        else begin m_rel = (int'(wdata) << 8) | m_lo; m_wptr = 0; ld = 1; end
        if (ld != 0) begin
          m_armed = 1;
          if (m_sq) begin m_cnt = halfn(m_rel, 1); m_out = 1; end
          else begin m_cnt = m_rel; m_out = 0; end
        end
      end else if (ticking) begin
        if (m_sq) begin
          if (c0 == 1) begin
            if (o0 && halfn(m_rel, 0) != 0) begin m_out = 0; m_cnt = halfn(m_rel, 0); end
            else begin m_out = 1; m_cnt = halfn(m_rel, 1); end
          end else m_cnt = c0 - 1;
        end else begin
          if (c0 == 1) m_out = 1;
          m_cnt = (c0 - 1) & 65535;
        end
      end
    end
  end

  task automatic check(input string t, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", t, act, exp, cyc);
    end
  endtask

  task automatic step(input bit w, input bit r, input logic [1:0] s, input logic [7:0] d);
    wr = w; rd = r; sel = s; wdata = d;
    tick = tick_on && ((cyc % tick_div) == 0);
    cyc++;
    @(negedge clk);
    check({tag, " spk_out (R11)"}, int'(spk_out), int'(m_out && m_spk));
    if (m_rd_valid) check({tag, " rdata (R12)"}, int'(rdata), m_rd_exp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 2'd0, 8'd0);
  endtask

  task automatic wmode(input logic [7:0] d); step(1, 0, 2'd1, d); endtask
  task automatic wdat(input logic [7:0] d);  step(1, 0, 2'd0, d); endtask
  task automatic wctl(input logic [7:0] d);  step(1, 0, 2'd2, d); endtask
  task automatic rdat();                     step(0, 1, 2'd0, 8'd0); endtask
  task automatic rctl();                     step(0, 1, 2'd2, 8'd0); endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tag = "R1";
    check("R1 spk_out after reset", int'(spk_out), 0);
    rctl();
    check("R1 control after reset", int'(rdata), 0);

    tag = "R10";
    wctl(8'hFF);
    rctl();
    check("R10 control masked", int'(rdata), 8'h03);

    tag = "R4";
    tick_on = 1'b1;
    wmode(8'hB0);
    wdat(8'd5);
    idle(12);
    check("R4 not armed after low byte", int'(spk_out), 0);
    wdat(8'd0);

    tag = "R6";
    idle(8);
    check("R6 still counting", int'(spk_out), 0);
    idle(6);
    check("R6 expired", int'(spk_out), 1);
    rctl();
    check("R6 status bit5", int'(rdata), 8'h23);
    idle(20);

    tag = "R7";
    wmode(8'h96);
    check("R7 high on square mode word", int'(spk_out), 1);
    wdat(8'd7);
    idle(60);
    wmode(8'hB6);
    wdat(8'h00);
    wdat(8'h01);
    idle(700);
    wmode(8'h96);
    wdat(8'd1);
    idle(20);
    check("R7 count one stays high", int'(spk_out), 1);

    tag = "R5";
    wmode(8'hB6);
    wdat(8'd40);
    wdat(8'd0);
    idle(9);
    wctl(8'h02);
    idle(30);
    rdat(); rdat();
    idle(30);
    rdat(); rdat();
    wctl(8'h03);
    idle(20);

    tag = "R8";
    wmode(8'hB0);
    wdat(8'h34);
    wdat(8'h12);
    idle(7);
    wmode(8'h80);
    idle(5);
    wmode(8'h80);
    idle(3);
    rdat();
    idle(4);
    rdat();
    rdat(); rdat();

    tag = "R9";
    wmode(8'hA0);
    wdat(8'h02);
    idle(3);
    rdat(); rdat();
    wmode(8'h90);
    wdat(8'h80);
    idle(3);
    rdat(); rdat();

    tag = "R3";
    idle(300);
    check("R3 low-only load expired", int'(spk_out), 1);
    wmode(8'hA0);
    wdat(8'h01);
    idle(400);
    check("R3 high-only load still counting", int'(spk_out), 0);
    idle(150);
    check("R3 high-only load expired", int'(spk_out), 1);

    tag = "R2";
    wmode(8'h30);
    idle(4);
    check("R2 foreign channel ignored", int'(spk_out), 1);
    wmode(8'hB1);
    wdat(8'd3);
    wdat(8'd0);
    idle(10);
    check("R2 format bit treated as binary", int'(spk_out), 1);

    tag = "R11";
    wctl(8'h01);
    idle(2);
    check("R11 speaker disabled", int'(spk_out), 0);
    rctl();
    check("R11 status still set", int'(rdata), 8'h21);
    wctl(8'h03);

    tag = "R12";
    step(0, 1, 2'd3, 8'd0);
    check("R12 unused select reads zero", int'(rdata), 0);

    tag = "R6";
    tick_div = 1;
    wmode(8'hB0);
    wdat(8'd0);
    wdat(8'd0);
    idle(65530);
    check("R6 zero count not yet expired", int'(spk_out), 0);
    idle(10);
    check("R6 zero count expired", int'(spk_out), 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule